// File: doc/BRIEF.md
# Daisy-Chained I2C Target with Self-Assigned Address

This block is the bus-facing front end of an I2C target that needs no address pins. Several devices share one bus and are wired in a chain. Each device has an active-low chain input that comes from the device before it, and an open-drain chain output that goes to the device after it. A device whose chain input is low, and which has no address yet, answers a shared power-up address. One write to that address gives the device its own address and locks it. The device then pulls its chain output low, and that releases the next device in the chain.

After an address phase matches, the block drives the acknowledge bit and emits a one-cycle strobe. The strobe carries a window code and the read/write bit. The window code says whether the byte hit the device itself, the broadcast address, or one of four port windows (port 0 or 1, primary or secondary). The port windows are placed from the device's instance number. Data bytes are acknowledged, but only the programming byte is stored. Reads beyond the address phase, clock stretching and port forwarding are not part of this block.

Top module: `chain_addr_target`

## Requirements
- R1: While the block is unprogrammed and the synchronized chain input `chain_in_n` is high, no address byte is acknowledged and `hit_stb_o` never pulses.
- R2: While unprogrammed, with `chain_in_n` low and `dev_en` high, the block acknowledges address byte 0x1E (write) and 0x1F (read).
- R3: The first data byte written to 0x1E with a valid value programs the self address. After that, 0x1E is no longer answered, and further writes to the self address are acknowledged but do not change it.
- R4: `chain_done_pull_o` is 0 after reset and while unprogrammed. It becomes 1 once programming completes and holds 1 from then on.
- R5: Once programmed, the level of `chain_in_n` has no effect on which addresses are answered.
- R6: While `dev_en` is low, the block is cleared to the unprogrammed state: it answers 0x1E again (given `chain_in_n` low) and releases `chain_done_pull_o`.
- R7: The block acknowledges the broadcast write address 0x02 whenever it is active, whether programmed or not. It does not acknowledge the broadcast read byte 0x03.
- R8: With self address S = 0x04 + 2n, the block answers the port windows P = 0x20 + 0x10·n, P+2, P+8 and P+10. Bit 0 of every address byte is the R/W bit (1 = read) and is not part of the match.
- R9: A programming byte whose bits 7:1 fall outside 2..15 (8-bit values 0x04..0x1F) is NACKed and leaves the block unprogrammed. Bit 0 of the programming byte is ignored, so 0x05 programs 0x04.
- R10: `sda_pull_o` holds SDA low throughout the ninth SCL pulse after a matched address byte and after each accepted data byte, and is released after that pulse.
- R11: Each matched address phase gives exactly one `hit_stb_o` cycle. The strobe carries `hit_win_o` (0 self, 1 broadcast, 2 port 0 primary, 3 port 0 secondary, 4 port 1 primary, 5 port 1 secondary) and `hit_rw_o` equal to address bit 0.
- R12: An address byte that does not match is NACKed, and the block ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_en | input | 1 | Device enable; low clears the programmed address |
| chain_in_n | input | 1 | Active-low chain enable from the previous device (pulled up externally) |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| chain_done_pull_o | output | 1 | 1 pulls the chain output low; 0 leaves it high-impedance |
| hit_stb_o | output | 1 | One-cycle pulse after a matched address phase |
| hit_win_o | output | 3 | Window code of the match |
| hit_rw_o | output | 1 | R/W bit of the matched address byte |

## Verification
SCL, SDA and the chain input each pass through two flops, and one more flop marks the edges. The acknowledge pull, the strobe and the programming update therefore appear about three clock edges after the host's SCL falling edge. The release of SDA follows three edges after the ninth falling edge, and a downstream chain input sees the change two edges after that. The bench holds each SCL low phase for four clocks before it changes SDA and each high phase for eight clocks. It reads the acknowledge in the middle of the ninth high phase, so every value has settled before it is sampled. Strobe contents are latched on falling clock edges and compared once the transaction has ended.

// File: rtl/cat_pkg.sv
package cat_pkg;

    typedef enum logic [2:0] {
        WIN_SELF   = 3'd0,
        WIN_BCAST  = 3'd1,
        WIN_P0_PRI = 3'd2,
        WIN_P0_SEC = 3'd3,
        WIN_P1_PRI = 3'd4,
        WIN_P1_SEC = 3'd5,
        WIN_NONE   = 3'd7
    } win_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_DATA     = 3'd3,
        ST_DATA_ACK = 3'd4,
        ST_SKIP     = 3'd5
    } bus_st_e;

endpackage

// File: rtl/cat_line_sync.sv
module cat_line_sync #(
    parameter int          STAGES = 2,
    parameter int          LINES  = 3,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] stg;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d = q;
        d.stg[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            d.stg[i] = q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{stg: {STAGES{{LINES{RST_VAL}}}}};
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.stg[STAGES-1];

endmodule

// File: rtl/cat_byte_engine.sv
module cat_byte_engine
    import cat_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_s,
    input  logic                 sda_s,
    input  logic                 addr_ack_i,
    input  logic                 data_ack_i,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 addr_evt_o,
    output logic                 data_evt_o,
    output logic                 sda_pull_o
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    typedef struct packed {
        bus_st_e              st;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] sh;
        logic                 pull;
        logic                 scl_p;
        logic                 sda_p;
    } eng_t;

    eng_t d, q;
    logic start_evt, stop_evt, rise_evt, fall_evt;

    always_comb begin
        start_evt = scl_s && q.scl_p && q.sda_p && !sda_s;
        stop_evt  = scl_s && q.scl_p && !q.sda_p && sda_s;
        rise_evt  = scl_s && !q.scl_p;
        fall_evt  = !scl_s && q.scl_p;
    end

    always_comb begin
        d = q;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        addr_evt_o = 1'b0;
        data_evt_o = 1'b0;
        if (start_evt) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else if (stop_evt) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_DATA: begin
                    if (rise_evt && (q.cnt < FULL)) begin
                        d.sh  = {q.sh[BYTE_BITS-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_evt && (q.cnt == FULL)) begin
                        if (q.st == ST_ADDR) begin
                            addr_evt_o = 1'b1;
                            d.st   = addr_ack_i ? ST_ADDR_ACK : ST_SKIP;
                            d.pull = addr_ack_i;
                        end else begin
                            data_evt_o = 1'b1;
                            d.st   = data_ack_i ? ST_DATA_ACK : ST_SKIP;
                            d.pull = data_ack_i;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall_evt) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.st   = q.sh[0] ? ST_SKIP : ST_DATA;
                    end
                end
                ST_DATA_ACK: begin
                    if (fall_evt) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, pull: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign byte_o     = q.sh;
    assign sda_pull_o = q.pull;

    AST_PULL_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q.pull |-> (q.st == ST_ADDR_ACK || q.st == ST_DATA_ACK)) else $error("pull outside ack"); // R10
    AST_PULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pull && scl_s && !start_evt && !stop_evt) |=> q.pull) else $error("ack dropped early"); // R10
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP && !start_evt) |=> !q.pull) else $error("ack while skipping"); // R12

endmodule

// File: rtl/cat_win_decode.sv
module cat_win_decode
    import cat_pkg::*;
#(
    parameter logic [7:0] BCAST_ADDR  = 8'h02,
    parameter logic [7:0] SELF_FIRST  = 8'h04,
    parameter logic [7:0] PORT_BASE   = 8'h20,
    parameter logic [7:0] PORT_STRIDE = 8'h10,
    parameter logic [7:0] PORT1_OFS   = 8'h08,
    parameter logic [7:0] SEC_OFS     = 8'h02
) (
    input  logic [7:0] abyte_i,
    input  logic [7:0] self_i,
    input  logic       active_i,
    output logic       hit_o,
    output logic [2:0] win_o
);
    localparam int NPORT = 4;

    logic [7:0]       inst;
    logic [7:0]       pbase;
    logic [NPORT-1:0] pm;
    logic             self_m, bc_m;

    assign inst  = (self_i - SELF_FIRST) >> 1;
    assign pbase = PORT_BASE + inst * PORT_STRIDE;

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        localparam logic [7:0] OFS = ((k / 2) != 0 ? PORT1_OFS : 8'h00)
                                   + ((k % 2) != 0 ? SEC_OFS : 8'h00);
        logic [7:0] waddr;
        assign waddr = pbase + OFS;
        assign pm[k] = active_i && (abyte_i[7:1] == waddr[7:1]);
    end

    assign self_m = active_i && (abyte_i[7:1] == self_i[7:1]);
    assign bc_m   = active_i && (abyte_i == BCAST_ADDR);

    always_comb begin
        hit_o = 1'b1;
        win_o = WIN_NONE;
        if (bc_m)            win_o = WIN_BCAST;
        else if (self_m)     win_o = WIN_SELF;
        else if (pm[0])      win_o = WIN_P0_PRI;
        else if (pm[1])      win_o = WIN_P0_SEC;
        else if (pm[2])      win_o = WIN_P1_PRI;
        else if (pm[3])      win_o = WIN_P1_SEC;
        else                 hit_o = 1'b0;
    end

endmodule

// File: rtl/chain_addr_target.sv
module chain_addr_target
    import cat_pkg::*;
#(
    parameter int         SYNC_STAGES  = 2,
    parameter logic [7:0] DEFAULT_ADDR = 8'h1E,
    parameter logic [7:0] BCAST_ADDR   = 8'h02,
    parameter logic [7:0] SELF_FIRST   = 8'h04,
    parameter logic [7:0] SELF_LAST    = 8'h1E,
    parameter logic [7:0] PORT_BASE    = 8'h20,
    parameter logic [7:0] PORT_STRIDE  = 8'h10,
    parameter logic [7:0] PORT1_OFS    = 8'h08,
    parameter logic [7:0] SEC_OFS      = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_en,
    input  logic       chain_in_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       chain_done_pull_o,
    output logic       hit_stb_o,
    output logic [2:0] hit_win_o,
    output logic       hit_rw_o
);
    typedef struct packed {
        logic       prog;
        logic [7:0] self_a;
        logic [2:0] win;
        logic       stb;
        logic       rw;
    } ctl_t;

    ctl_t d, q;

    logic [2:0] lines_s;
    logic       scl_s, sda_s, chain_s;
    logic [7:0] rx_byte;
    logic       addr_evt, data_evt;
    logic       addr_ack, data_ack;
    logic       active, prog_ok;
    logic [2:0] dec_win;

    cat_line_sync #(.STAGES(SYNC_STAGES), .LINES(3), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({chain_in_n, sda_i, scl_i}),
        .sync_o (lines_s)
    );
    assign scl_s   = lines_s[0];
    assign sda_s   = lines_s[1];
    assign chain_s = lines_s[2];

    assign active = dev_en && (q.prog || !chain_s);

    cat_win_decode #(
        .BCAST_ADDR(BCAST_ADDR), .SELF_FIRST(SELF_FIRST), .PORT_BASE(PORT_BASE),
        .PORT_STRIDE(PORT_STRIDE), .PORT1_OFS(PORT1_OFS), .SEC_OFS(SEC_OFS)
    ) u_dec (
        .abyte_i  (rx_byte),
        .self_i   (q.self_a),
        .active_i (active),
        .hit_o    (addr_ack),
        .win_o    (dec_win)
    );

    assign prog_ok  = (rx_byte[7:1] >= SELF_FIRST[7:1]) && (rx_byte[7:1] <= SELF_LAST[7:1]);
    assign data_ack = (q.win != WIN_SELF) || q.prog || prog_ok;

    cat_byte_engine #(.BYTE_BITS(8)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .addr_ack_i (addr_ack),
        .data_ack_i (data_ack),
        .byte_o     (rx_byte),
        .addr_evt_o (addr_evt),
        .data_evt_o (data_evt),
        .sda_pull_o (sda_pull_o)
    );

    always_comb begin
        d = q;
        d.stb = 1'b0;
        if (addr_evt && addr_ack) begin
            d.stb = 1'b1;
            d.win = dec_win;
            d.rw  = rx_byte[0];
        end
        if (data_evt && (q.win == WIN_SELF) && !q.prog && prog_ok) begin
            d.prog   = 1'b1;
            d.self_a = {rx_byte[7:1], 1'b0};
        end
        if (!dev_en) begin
            d.prog   = 1'b0;
            d.self_a = DEFAULT_ADDR;
            d.stb    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{prog: 1'b0, self_a: DEFAULT_ADDR, win: WIN_NONE, stb: 1'b0, rw: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign chain_done_pull_o = q.prog;
    assign hit_stb_o         = q.stb;
    assign hit_win_o         = q.win;
    assign hit_rw_o          = q.rw;

    AST_SELF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.prog && $past(q.prog)) |-> $stable(q.self_a)) else $error("self address changed"); // R3
    AST_PROG_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.prog) |-> $past(data_evt)) else $error("programmed without data byte"); // R3
    AST_SELF_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        q.prog |-> (q.self_a >= SELF_FIRST && q.self_a <= SELF_LAST && !q.self_a[0])) else $error("bad self"); // R9
    AST_UNPROG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !q.prog |-> (q.self_a == DEFAULT_ADDR)) else $error("unprogrammed not default"); // R6
    AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> sda_pull_o) else $error("strobe without ack"); // R11
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb) else $error("strobe longer than a cycle"); // R11

endmodule

// File: tb/chain_addr_target_tb.sv
module chain_addr_target_tb;
    localparam int Q = 4;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic a_en_n = 1'b1;
    logic a_dev = 1'b1, b_dev = 1'b1;
    logic a_pull, b_pull, a_done, b_done;
    logic a_stb, b_stb, a_rw, b_rw;
    logic [2:0] a_win, b_win;
    logic sda_bus, b_en_n;

    int total = 0, bad = 0;
    int a_cnt = 0, b_cnt = 0;
    int a_wl = 7, b_wl = 7, a_rl = 0, b_rl = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    assign sda_bus = !(host_low || a_pull || b_pull);
    assign b_en_n  = !a_done;

    chain_addr_target u_dut (
        .clk(clk), .rst_n(rst_n), .dev_en(a_dev), .chain_in_n(a_en_n),
        .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(a_pull), .chain_done_pull_o(a_done),
        .hit_stb_o(a_stb), .hit_win_o(a_win), .hit_rw_o(a_rw));

    chain_addr_target u_next (
        .clk(clk), .rst_n(rst_n), .dev_en(b_dev), .chain_in_n(b_en_n),
        .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(b_pull), .chain_done_pull_o(b_done),
        .hit_stb_o(b_stb), .hit_win_o(b_win), .hit_rw_o(b_rw));

    always @(negedge clk) begin
        cyc++;
        if (a_stb) begin a_cnt++; a_wl = int'(a_win); a_rl = int'(a_rw); end
        if (b_stb) begin b_cnt++; b_wl = int'(b_win); b_rl = int'(b_rw); end
        if (cyc == 190000) begin
            total++; bad++;
            $display("FAIL watchdog: act=expired exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        host_low = 1'b0; scl = 1'b1; wt(H);
        host_low = 1'b1; wt(H);
        scl = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        host_low = 1'b1; wt(Q);
        scl = 1'b1; wt(H);
        host_low = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_low = !b[i]; wt(Q);
            scl = 1'b1; wt(H);
            scl = 1'b0; wt(Q);
        end
        host_low = 1'b0; wt(Q);
        scl = 1'b1; wt(H / 2);
        ack = !sda_bus;
        wt(H / 2);
        scl = 1'b0; wt(Q);
    endtask

    task automatic addr_only(input logic [7:0] a, output logic ack);
        i2c_start();
        send_byte(a, ack);
        i2c_stop();
    endtask

    task automatic write1(input logic [7:0] a, input logic [7:0] v, output logic aa, output logic da);
        i2c_start();
        send_byte(a, aa);
        da = 1'b0;
        if (aa) send_byte(v, da);
        i2c_stop();
    endtask

    function automatic logic dev_ack(input logic [7:0] a, input logic act, input logic [7:0] s);
        logic [7:0] n, p;
        if (!act) return 1'b0;
        if (a == 8'h02) return 1'b1;
        if (a[7:1] == s[7:1]) return 1'b1;
        n = (s - 8'h04) >> 1;
        p = 8'h20 + 8'h10 * n;
        return (a[7:1] == p[7:1]) || (a[7:1] == 7'(p[7:1] + 7'd1)) ||
               (a[7:1] == 7'(p[7:1] + 7'd4)) || (a[7:1] == 7'(p[7:1] + 7'd5));
    endfunction

    task automatic sweep(input logic aact, input logic [7:0] aself,
                         input logic bact, input logic [7:0] bself);
        int ea = 0, eb = 0, a0, b0;
        logic ack, xa, xb;
        a0 = a_cnt; b0 = b_cnt;
        for (int v = 0; v < 256; v++) begin
            xa = dev_ack(8'(v), aact, aself);
            xb = dev_ack(8'(v), bact, bself);
            ea += int'(xa); eb += int'(xb);
            addr_only(8'(v), ack);
            if (v[7:1] == 7'd1) check("R7 broadcast sweep", int'(ack), int'(xa | xb));
            else if (xa | xb) check("R8 window sweep", int'(ack), 1);
            else check("R12 unmatched sweep", int'(ack), 0);
        end
        check("R11 strobe count first", a_cnt - a0, ea);
        check("R11 strobe count second", b_cnt - b0, eb);
    endtask

    initial begin
        logic ack, aa, da;
        int c0;
        wt(4);
        check("R4 reset pull", int'(a_pull), 0);
        check("R4 reset done", int'(a_done), 0);
        check("R11 reset strobe", int'(a_stb), 0);
        rst_n = 1'b1; wt(4);

        // R1: chain input high, nothing answered
        c0 = a_cnt;
        addr_only(8'h1E, ack); check("R1 default ignored", int'(ack), 0);
        addr_only(8'h02, ack); check("R1 broadcast ignored", int'(ack), 0);
        check("R1 no strobe", a_cnt - c0, 0);

        a_en_n = 1'b0; wt(4);
        // R2/R7/R8/R12 sweep: first device default, second inactive
        sweep(1'b1, 8'h1E, 1'b0, 8'h1E);
        check("R1 second stays silent", b_cnt, 0);

        // R11 window codes at default instance 13
        write1(8'hF8, 8'h33, aa, da);
        check("R11 win p1 pri", a_wl, 4); check("R11 rw write", a_rl, 0);
        addr_only(8'hF3, ack);
        check("R11 win p0 sec", a_wl, 3); check("R11 rw read", a_rl, 1);
        addr_only(8'h1F, ack); check("R2 default read", int'(ack), 1);
        check("R11 win self", a_wl, 0);

        // R9: invalid programming bytes
        write1(8'h1E, 8'h21, aa, da);
        check("R2 default ack", int'(aa), 1); check("R9 0x21 nack", int'(da), 0);
        write1(8'h1E, 8'h02, aa, da); check("R9 0x02 nack", int'(da), 0);
        check("R4 still unprogrammed", int'(a_done), 0);

        // R9/R3/R4: program first device with 0x05 -> 0x04
        write1(8'h1E, 8'h05, aa, da); check("R9 0x05 accepted", int'(da), 1);
        wt(2);
        check("R4 done driven", int'(a_done), 1);
        addr_only(8'h04, ack); check("R3 new address", int'(ack), 1);

        // R10: data byte acked after port window
        write1(8'h28, 8'h55, aa, da);
        check("R10 addr ack", int'(aa), 1); check("R10 data ack", int'(da), 1);
        check("R11 win n0 p1 pri", a_wl, 4);

        // R3: lock
        write1(8'h04, 8'h08, aa, da); check("R3 locked write acked", int'(da), 1);
        addr_only(8'h08, ack); check("R3 locked no move", int'(ack), 0);
        addr_only(8'h04, ack); check("R3 keeps address", int'(ack), 1);

        // program second device through the default address
        write1(8'h1E, 8'h06, aa, da);
        check("R2 second default ack", int'(aa), 1); check("R3 second programmed", int'(da), 1);
        wt(2);
        check("R4 second done", int'(b_done), 1);
        addr_only(8'h1E, ack); check("R3 default now silent", int'(ack), 0);

        // R5: chain input irrelevant once programmed
        a_en_n = 1'b1; wt(4);
        addr_only(8'h04, ack); check("R5 chain high still answers", int'(ack), 1);

        sweep(1'b1, 8'h04, 1'b1, 8'h06);
        addr_only(8'h3B, ack);
        check("R11 second win p1 sec", b_wl, 5); check("R11 second rw", b_rl, 1);

        // R6: device enable pulse
        a_en_n = 1'b0;
        a_dev = 1'b0; wt(3); a_dev = 1'b1; wt(4);
        check("R6 done released", int'(a_done), 0);
        addr_only(8'h04, ack); check("R6 old address gone", int'(ack), 0);
        addr_only(8'h1E, ack); check("R6 default back", int'(ack), 1);
        addr_only(8'h06, ack); check("R5 second keeps address", int'(ack), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule